// File: doc/BRIEF.md
# Trap and Interrupt Context Controller

This unit owns the control-flow context changes that a processor core makes on a subroutine call, a return, a system call, a software interrupt and an interrupt return. The core presents one decoded control instruction at a time, together with its own instruction pointer, stack pointer and 32-bit flag word. The unit updates three save registers, which hold a link address, a saved stack pointer and a saved flag word. It then reports the instruction pointer, stack pointer and flags the core should continue with. Entry addresses come from a small vector table held inside the unit. The table is filled through a dedicated write port and has no reset.

Instructions arrive on a valid/ready input. The unit accepts an instruction on a rising edge where `ins_valid` and `ins_ready` are both high. The result appears on the `nxt_*` outputs one cycle later, marked by a single-cycle `nxt_valid` pulse. `ins_ready` is low from reset until the boot cycle is done and high from then on. While it is low the unit ignores `ins_valid` and the other instruction inputs, so the core must hold its instruction until it sees ready. Each opcode has a mode bit. Opcodes with mode 0 (software interrupt and interrupt return) need kernel mode, which means flag bit 16 is clear. If one of them arrives in user mode, the unit takes a fault through a fixed vector instead.

Top module: `trap_ctx_ctrl`

## Requirements
- R1: While reset is asserted, `ins_ready`, `nxt_valid`, `nxt_fault`, `nxt_flg` and all three save registers read zero.
- R2: On the first rising edge after reset is released, `nxt_ip` loads vector table entry 0, `nxt_valid` pulses for one cycle and `ins_ready` goes high and stays high.
- R3: An instruction is accepted only on an edge where `ins_valid` and `ins_ready` are both high. Its result and a one-cycle `nxt_valid` pulse appear after that edge. An instruction presented while `ins_ready` is low changes nothing.
- R4: Opcode 0, and any opcode other than 160, 161, 162, 192 and 193, passes `cur_ip`, `cur_sp` and `cur_flg` to the outputs and leaves the save registers unchanged.
- R5: Call (opcode 160) swaps the link: `nxt_ip` takes the old save0 and save0 takes `cur_ip`. SP and flags pass through.
- R6: Return (opcode 161) sets `nxt_ip` to save0 and leaves all save registers unchanged. SP and flags pass through.
- R7: System call (opcode 162) stores `cur_ip`, `cur_sp` and `cur_flg` into save0, save1 and save2, and sets `nxt_ip` to vector table entry 6. It is allowed in both modes.
- R8: Software interrupt (opcode 192) in kernel mode does the same three saves and sets `nxt_ip` to the vector table entry selected by the low log2(DEPTH) bits of `ins_imm`. The upper immediate bits are ignored.
- R9: On every entry (system call, software interrupt, fault), `nxt_sp` equals the value just stored in save1 (that is, `cur_sp`). `nxt_flg` equals `cur_flg` with bits 16 and 17 cleared.
- R10: Interrupt return (opcode 193) in kernel mode sets `nxt_ip`, `nxt_sp` and `nxt_flg` to save0, save1 and save2. The save registers are unchanged.
- R11: Opcode 192 or 193 with `cur_flg` bit 16 set (user mode) does the entry saves, sets `nxt_ip` to vector table entry 13, clears flag bits 16 and 17 and raises `nxt_fault` together with `nxt_valid`. Opcodes 160 to 162 never fault.
- R12: A vector table write lands on the rising edge where `vt_wr_en` is high. A read on that same edge still returns the entry's old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ins_valid | input | 1 | Instruction present |
| ins_ready | output | 1 | Unit can accept an instruction |
| ins_opcode | input | 8 | Decoded opcode |
| ins_imm | input | 8 | Vector immediate |
| cur_ip | input | XLEN | Current instruction pointer |
| cur_sp | input | XLEN | Current stack pointer |
| cur_flg | input | XLEN | Current flag word (bit 16 = user mode) |
| vt_wr_en | input | 1 | Vector table write strobe |
| vt_wr_idx | input | log2(DEPTH) | Vector table write index |
| vt_wr_data | input | XLEN | Vector table write data |
| nxt_valid | output | 1 | One-cycle pulse marking a new result |
| nxt_ip | output | XLEN | Next instruction pointer |
| nxt_sp | output | XLEN | Next stack pointer |
| nxt_flg | output | XLEN | Next flag word |
| nxt_fault | output | 1 | Result is a privilege fault |
| save0 | output | XLEN | Link / saved IP register |
| save1 | output | XLEN | Saved SP register |
| save2 | output | XLEN | Saved flags register |

## Verification
A wrong save register does not show up when it is written. It shows up on the next return or interrupt return, which hands the stale value to `nxt_ip`, `nxt_sp` or `nxt_flg`. The save registers are therefore also compared directly one cycle after every accepted instruction. Decode or privilege errors show up one cycle after acceptance, as a wrong vector address or a missing or extra `nxt_fault`. The sweep therefore covers every immediate value in both modes and every opcode class, and it interleaves entries with returns so that a stale link reaches the outputs within one or two instructions.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

  localparam logic [7:0] OPC_NOP     = 8'd0;
  localparam logic [7:0] OPC_CALL    = 8'd160;
  localparam logic [7:0] OPC_RET     = 8'd161;
  localparam logic [7:0] OPC_SYSCALL = 8'd162;
  localparam logic [7:0] OPC_SWI     = 8'd192;
  localparam logic [7:0] OPC_IRET    = 8'd193;

  // Action the unit takes for one accepted instruction
  typedef enum logic [2:0] {
    ACT_PASS  = 3'd0,
    ACT_CALL  = 3'd1,
    ACT_RET   = 3'd2,
    ACT_ENTER = 3'd3,
    ACT_IRET  = 3'd4
  } ctx_act_e;

  // Source of the vector table read index
  typedef enum logic [1:0] {
    VS_BOOT    = 2'd0,
    VS_SYSCALL = 2'd1,
    VS_IMM     = 2'd2,
    VS_FAULT   = 2'd3
  } vec_sel_e;

  typedef struct packed {
    ctx_act_e act;
    vec_sel_e vsel;
    logic     fault;
    logic     ld_link;
    logic     ld_all;
  } ctx_dec_t;

endpackage

// File: rtl/ctx_decode.sv
module ctx_decode
  import ctx_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic       user_mode,
  output ctx_dec_t   dec
);

  // Mode bit per opcode: 0 marks an operation reserved to kernel mode
  function automatic logic op_mode(input logic [7:0] op);
    logic m;
    unique case (op)
      OPC_SWI, OPC_IRET: m = 1'b0;
      default:           m = 1'b1;
    endcase
    return m;
  endfunction

  logic denied;

  always_comb begin
    denied      = (op_mode(opcode) == 1'b0) && user_mode;
    dec.act     = ACT_PASS;
    dec.vsel    = VS_SYSCALL;
    dec.fault   = 1'b0;
    dec.ld_link = 1'b0;
    dec.ld_all  = 1'b0;
    if (denied) begin
      dec.act    = ACT_ENTER;
      dec.vsel   = VS_FAULT;
      dec.fault  = 1'b1;
      dec.ld_all = 1'b1;
    end else begin
      unique case (opcode)
        OPC_CALL: begin
          dec.act     = ACT_CALL;
          dec.ld_link = 1'b1;
        end
        OPC_RET: dec.act = ACT_RET;
        OPC_SYSCALL: begin
          dec.act    = ACT_ENTER;
          dec.vsel   = VS_SYSCALL;
          dec.ld_all = 1'b1;
        end
        OPC_SWI: begin
          dec.act    = ACT_ENTER;
          dec.vsel   = VS_IMM;
          dec.ld_all = 1'b1;
        end
        OPC_IRET: dec.act = ACT_IRET;
        default:  dec.act = ACT_PASS;
      endcase
    end
  end

endmodule

// File: rtl/ctx_vector_table.sv
module ctx_vector_table #(
  parameter int XLEN  = 32,
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]  wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [XLEN-1:0]  rd_data
);

  logic [XLEN-1:0] ent [DEPTH];

  // No reset: contents are loaded by software through the write port
  always_ff @(posedge clk) begin
    for (int k = 0; k < DEPTH; k++) begin
      if (wr_en && (wr_idx == IDX_W'(k))) ent[k] <= wr_data;
    end
  end

  assign rd_data = ent[rd_idx];

endmodule

// File: rtl/ctx_save_bank.sv
module ctx_save_bank #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_link,
  input  logic            ld_all,
  input  logic [XLEN-1:0] ip_in,
  input  logic [XLEN-1:0] sp_in,
  input  logic [XLEN-1:0] flg_in,
  output logic [XLEN-1:0] s_ip,
  output logic [XLEN-1:0] s_sp,
  output logic [XLEN-1:0] s_flg
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_ip  <= '0;
      s_sp  <= '0;
      s_flg <= '0;
    end else begin
      if (ld_link || ld_all) s_ip <= ip_in;
      if (ld_all) begin
        s_sp  <= sp_in;
        s_flg <= flg_in;
      end
    end
  end

endmodule

// File: rtl/ctx_next.sv
module ctx_next
  import ctx_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int USER_BIT = 16,
  parameter int IE_BIT   = 17
) (
  input  ctx_act_e        act,
  input  logic [XLEN-1:0] cur_ip,
  input  logic [XLEN-1:0] cur_sp,
  input  logic [XLEN-1:0] cur_flg,
  input  logic [XLEN-1:0] s_ip,
  input  logic [XLEN-1:0] s_sp,
  input  logic [XLEN-1:0] s_flg,
  input  logic [XLEN-1:0] vec,
  output logic [XLEN-1:0] n_ip,
  output logic [XLEN-1:0] n_sp,
  output logic [XLEN-1:0] n_flg
);

  localparam logic [XLEN-1:0] ENTRY_CLR =
    (XLEN'(1) << USER_BIT) | (XLEN'(1) << IE_BIT);

  always_comb begin
    n_ip  = cur_ip;
    n_sp  = cur_sp;
    n_flg = cur_flg;
    unique case (act)
      ACT_CALL: n_ip = s_ip;
      ACT_RET:  n_ip = s_ip;
      ACT_ENTER: begin
        // SP is reloaded from the slot being written this cycle: cur_sp
        n_ip  = vec;
        n_sp  = cur_sp;
        n_flg = cur_flg & ~ENTRY_CLR;
      end
      ACT_IRET: begin
        n_ip  = s_ip;
        n_sp  = s_sp;
        n_flg = s_flg;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/trap_ctx_ctrl.sv
module trap_ctx_ctrl
  import ctx_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int DEPTH       = 16,
  parameter int BOOT_VEC    = 0,
  parameter int SYSCALL_VEC = 6,
  parameter int FAULT_VEC   = 13,
  parameter int USER_BIT    = 16,
  parameter int IE_BIT      = 17
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ins_valid,
  output logic                     ins_ready,
  input  logic [7:0]               ins_opcode,
  input  logic [7:0]               ins_imm,
  input  logic [XLEN-1:0]          cur_ip,
  input  logic [XLEN-1:0]          cur_sp,
  input  logic [XLEN-1:0]          cur_flg,
  input  logic                     vt_wr_en,
  input  logic [$clog2(DEPTH)-1:0] vt_wr_idx,
  input  logic [XLEN-1:0]          vt_wr_data,
  output logic                     nxt_valid,
  output logic [XLEN-1:0]          nxt_ip,
  output logic [XLEN-1:0]          nxt_sp,
  output logic [XLEN-1:0]          nxt_flg,
  output logic                     nxt_fault,
  output logic [XLEN-1:0]          save0,
  output logic [XLEN-1:0]          save1,
  output logic [XLEN-1:0]          save2
);

  localparam int IDX_W = $clog2(DEPTH);

  logic             boot_q;
  logic             fire;
  ctx_dec_t         dec;
  vec_sel_e         vsel;
  logic [IDX_W-1:0] rd_idx;
  logic [XLEN-1:0]  vec;
  logic [XLEN-1:0]  n_ip, n_sp, n_flg;

  assign ins_ready = !boot_q;
  assign fire      = ins_valid && ins_ready;

  ctx_decode u_dec (
    .opcode    (ins_opcode),
    .user_mode (cur_flg[USER_BIT]),
    .dec       (dec)
  );

  assign vsel = boot_q ? VS_BOOT : dec.vsel;

  always_comb begin
    unique case (vsel)
      VS_BOOT:    rd_idx = IDX_W'(BOOT_VEC);
      VS_SYSCALL: rd_idx = IDX_W'(SYSCALL_VEC);
      VS_IMM:     rd_idx = IDX_W'(ins_imm);
      default:    rd_idx = IDX_W'(FAULT_VEC);
    endcase
  end

  ctx_vector_table #(.XLEN(XLEN), .DEPTH(DEPTH)) u_vt (
    .clk     (clk),
    .wr_en   (vt_wr_en),
    .wr_idx  (vt_wr_idx),
    .wr_data (vt_wr_data),
    .rd_idx  (rd_idx),
    .rd_data (vec)
  );

  ctx_save_bank #(.XLEN(XLEN)) u_save (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_link (fire && dec.ld_link),
    .ld_all  (fire && dec.ld_all),
    .ip_in   (cur_ip),
    .sp_in   (cur_sp),
    .flg_in  (cur_flg),
    .s_ip    (save0),
    .s_sp    (save1),
    .s_flg   (save2)
  );

  ctx_next #(.XLEN(XLEN), .USER_BIT(USER_BIT), .IE_BIT(IE_BIT)) u_next (
    .act     (dec.act),
    .cur_ip  (cur_ip),
    .cur_sp  (cur_sp),
    .cur_flg (cur_flg),
    .s_ip    (save0),
    .s_sp    (save1),
    .s_flg   (save2),
    .vec     (vec),
    .n_ip    (n_ip),
    .n_sp    (n_sp),
    .n_flg   (n_flg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_q    <= 1'b1;
      nxt_valid <= 1'b0;
      nxt_fault <= 1'b0;
      nxt_ip    <= '0;
      nxt_sp    <= '0;
      nxt_flg   <= '0;
    end else if (boot_q) begin
      boot_q    <= 1'b0;
      nxt_valid <= 1'b1;
      nxt_fault <= 1'b0;
      nxt_ip    <= vec;
    end else if (fire) begin
      nxt_valid <= 1'b1;
      nxt_fault <= dec.fault;
      nxt_ip    <= n_ip;
      nxt_sp    <= n_sp;
      nxt_flg   <= n_flg;
    end else begin
      nxt_valid <= 1'b0;
      nxt_fault <= 1'b0;
    end
  end

endmodule

// File: rtl/trap_ctx_ctrl_chk.sv
module trap_ctx_ctrl_chk #(
  parameter int XLEN     = 32,
  parameter int USER_BIT = 16,
  parameter int IE_BIT   = 17
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ins_valid,
  input logic            ins_ready,
  input logic [7:0]      ins_opcode,
  input logic [XLEN-1:0] cur_ip,
  input logic [XLEN-1:0] cur_sp,
  input logic [XLEN-1:0] cur_flg,
  input logic            nxt_valid,
  input logic [XLEN-1:0] nxt_ip,
  input logic [XLEN-1:0] nxt_sp,
  input logic [XLEN-1:0] nxt_flg,
  input logic            nxt_fault,
  input logic [XLEN-1:0] save0,
  input logic [XLEN-1:0] save1,
  input logic [XLEN-1:0] save2
);

  logic fire;
  assign fire = ins_valid && ins_ready;

  a_r2_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ins_ready) |-> ins_ready);

  a_r2_boot_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ins_ready) |-> nxt_valid);

  a_r3_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> nxt_valid);

  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_ready && !ins_valid) |=> !nxt_valid);

  a_r4_nop_keeps_saves: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ins_opcode == 8'd0) |=>
      (save0 == $past(save0) && save1 == $past(save1) && save2 == $past(save2)));

  a_r5_call_swap: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ins_opcode == 8'd160) |=>
      (nxt_ip == $past(save0) && save0 == $past(cur_ip)));

  a_r7_syscall_saves: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ins_opcode == 8'd162) |=>
      (save0 == $past(cur_ip) && save1 == $past(cur_sp) && save2 == $past(cur_flg)));

  a_r9_fault_flags: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_fault |-> (!nxt_flg[USER_BIT] && !nxt_flg[IE_BIT] && nxt_sp == save1));

  a_r10_iret_restore: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ins_opcode == 8'd193 && !cur_flg[USER_BIT]) |=>
      (nxt_ip == save0 && nxt_sp == save1 && nxt_flg == save2));

  a_r11_user_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (ins_opcode == 8'd192 || ins_opcode == 8'd193) && cur_flg[USER_BIT])
      |=> nxt_fault);

  a_r11_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_fault |-> nxt_valid);

endmodule

bind trap_ctx_ctrl trap_ctx_ctrl_chk #(
  .XLEN(XLEN), .USER_BIT(USER_BIT), .IE_BIT(IE_BIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ins_valid  (ins_valid),
  .ins_ready  (ins_ready),
  .ins_opcode (ins_opcode),
  .cur_ip     (cur_ip),
  .cur_sp     (cur_sp),
  .cur_flg    (cur_flg),
  .nxt_valid  (nxt_valid),
  .nxt_ip     (nxt_ip),
  .nxt_sp     (nxt_sp),
  .nxt_flg    (nxt_flg),
  .nxt_fault  (nxt_fault),
  .save0      (save0),
  .save1      (save1),
  .save2      (save2)
);

// File: tb/trap_ctx_ctrl_tb.sv
module trap_ctx_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ins_valid;
  logic        ins_ready;
  logic [7:0]  ins_opcode;
  logic [7:0]  ins_imm;
  logic [31:0] cur_ip, cur_sp, cur_flg;
  logic        vt_wr_en;
  logic [3:0]  vt_wr_idx;
  logic [31:0] vt_wr_data;
  logic        nxt_valid;
  logic [31:0] nxt_ip, nxt_sp, nxt_flg;
  logic        nxt_fault;
  logic [31:0] save0, save1, save2;

  always #10 clk = ~clk;

  trap_ctx_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_opcode(ins_opcode), .ins_imm(ins_imm),
    .cur_ip(cur_ip), .cur_sp(cur_sp), .cur_flg(cur_flg),
    .vt_wr_en(vt_wr_en), .vt_wr_idx(vt_wr_idx), .vt_wr_data(vt_wr_data),
    .nxt_valid(nxt_valid), .nxt_ip(nxt_ip), .nxt_sp(nxt_sp), .nxt_flg(nxt_flg),
    .nxt_fault(nxt_fault), .save0(save0), .save1(save1), .save2(save2)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [31:0] mtbl [16];
  logic [31:0] m0, m1, m2;

  localparam logic [31:0] CLR = 32'h0003_0000;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Apply one instruction, model it, and compare everything one cycle later
  task automatic apply(input logic [7:0] op, input logic [7:0] imm,
                       input logic [31:0] ip, input logic [31:0] sp,
                       input logic [31:0] flg);
    logic [31:0] eip, esp, eflg;
    logic        efault;
    string       req;
    bit          kern, entry;
    kern   = !flg[16];
    eip    = ip; esp = sp; eflg = flg; efault = 1'b0; entry = 1'b0;
    req    = "R4";
    if ((op == 8'd192 || op == 8'd193) && !kern) begin
      req = "R11"; entry = 1'b1; efault = 1'b1;
      m0 = ip; m1 = sp; m2 = flg;
      eip = mtbl[13]; eflg = flg & ~CLR;
    end else begin
      case (op)
        8'd160: begin req = "R5"; eip = m0; m0 = ip; end
        8'd161: begin req = "R6"; eip = m0; end
        8'd162: begin
          req = "R7"; entry = 1'b1;
          m0 = ip; m1 = sp; m2 = flg; eip = mtbl[6]; eflg = flg & ~CLR;
        end
        8'd192: begin
          req = "R8"; entry = 1'b1;
          m0 = ip; m1 = sp; m2 = flg; eip = mtbl[imm[3:0]]; eflg = flg & ~CLR;
        end
        8'd193: begin req = "R10"; eip = m0; esp = m1; eflg = m2; end
        default: req = "R4";
      endcase
    end
    ins_opcode = op; ins_imm = imm; cur_ip = ip; cur_sp = sp; cur_flg = flg;
    ins_valid  = 1'b1;
    @(negedge clk);
    ins_valid  = 1'b0;
    check(nxt_valid == 1'b1 && nxt_fault == efault, req, "valid/fault",
          {30'd0, nxt_valid, nxt_fault}, {30'd0, 1'b1, efault});
    check(nxt_ip == eip, req, "nxt_ip", nxt_ip, eip);
    check(nxt_sp == esp && nxt_flg == eflg, req, "nxt_sp^flg",
          nxt_sp ^ nxt_flg, esp ^ eflg);
    check(save0 == m0 && save1 == m1 && save2 == m2, req, "saves",
          save0 ^ save1 ^ save2, m0 ^ m1 ^ m2);
    if (entry)
      check(nxt_sp == sp && nxt_flg[17:16] == 2'b00, "R9", "entry sp/flags",
            {nxt_flg[17:16], nxt_sp[29:0]}, {2'b00, sp[29:0]});
  endtask

  logic [7:0] ops [10] = '{8'd0, 8'd160, 8'd161, 8'd162, 8'd192, 8'd193,
                           8'd1, 8'd64, 8'd128, 8'd255};

  initial begin
    rst_n = 1'b0; ins_valid = 1'b0; ins_opcode = '0; ins_imm = '0;
    cur_ip = '0; cur_sp = '0; cur_flg = '0;
    vt_wr_en = 1'b0; vt_wr_idx = '0; vt_wr_data = '0;
    m0 = '0; m1 = '0; m2 = '0;
    @(negedge clk);
    // R1: reset state
    check(!ins_ready && !nxt_valid && !nxt_fault, "R1", "ready/valid/fault",
          {29'd0, ins_ready, nxt_valid, nxt_fault}, 32'd0);
    check(nxt_flg == 0 && save0 == 0 && save1 == 0 && save2 == 0, "R1",
          "flags/saves", nxt_flg | save0 | save1 | save2, 32'd0);
    // Fill vector table while in reset (R12 write path)
    for (int k = 0; k < 16; k++) begin
      mtbl[k]    = 32'h4000_0000 + 32'(k) * 32'h0000_0124 + 32'(k * k);
      vt_wr_en   = 1'b1;
      vt_wr_idx  = 4'(k);
      vt_wr_data = mtbl[k];
      @(negedge clk);
    end
    vt_wr_en = 1'b0;
    // Release reset with a call offered while not ready (R3: ignored)
    rst_n = 1'b1;
    ins_valid = 1'b1; ins_opcode = 8'd160; cur_ip = 32'hDEAD_0000;
    @(negedge clk);
    ins_valid = 1'b0;
    check(nxt_valid && ins_ready && nxt_ip == mtbl[0], "R2", "boot nxt_ip",
          nxt_ip, mtbl[0]);
    check(save0 == 32'd0, "R3", "save0 after unready call", save0, 32'd0);
    @(negedge clk);
    check(!nxt_valid && ins_ready, "R3", "idle no pulse",
          {30'd0, nxt_valid, ins_ready}, 32'd1);
    check(!nxt_valid && ins_ready, "R2", "ready stays high",
          {31'd0, ins_ready}, 32'd1);

    // Sweep: every opcode class, both modes, several operand patterns
    for (int r = 0; r < 6; r++) begin
      for (int p = 0; p < 2; p++) begin
        for (int o = 0; o < 10; o++) begin
          int n;
          logic [31:0] f;
          n = r * 20 + p * 10 + o;
          f = 32'(n) * 32'h9E37_79B9;
          f[16] = p[0];
          apply(ops[o], 8'(n * 37), 32'h0001_0000 + 32'(n) * 4,
                32'hFFF0_0000 - 32'(n) * 8, f);
        end
      end
    end

    // R8: every immediate value, each followed by iret; in user mode -> R11
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < 256; i++) begin
        logic [31:0] f;
        f = 32'(i) * 32'h0101_0303 | 32'h0002_0000;
        f[16] = p[0];
        apply(8'd192, 8'(i), 32'h0020_0000 + 32'(i), 32'h7000_0000 - 32'(i), f);
        apply(8'd193, 8'd0, 32'h0030_0000, 32'h1111_0000, 32'h0000_0005);
      end
    end

    // Call/return chains to expose stale links
    for (int i = 0; i < 8; i++) begin
      apply(8'd160, 8'd0, 32'h0050_0000 + 32'(i * 16), 32'h2000, 32'h0001_0000);
      apply(8'd161, 8'd0, 32'h0060_0000, 32'h2004, 32'h0);
    end

    // R12: write entry 6 on the same edge as a system call
    vt_wr_en = 1'b1; vt_wr_idx = 4'd6; vt_wr_data = 32'hCAFE_0600;
    apply(8'd162, 8'd0, 32'h0070_0000, 32'h3000, 32'h0);
    vt_wr_en = 1'b0;
    mtbl[6] = 32'hCAFE_0600;
    apply(8'd162, 8'd0, 32'h0070_0004, 32'h3004, 32'h0001_0000);
    check(nxt_ip == 32'hCAFE_0600, "R12", "new entry used", nxt_ip, 32'hCAFE_0600);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule